// File: doc/BRIEF.md
# PCI Host Bridge Bring-Up Sequencer

This block takes a PCI host bridge from cold reset to a usable state without software help. When a start pulse arrives, it raises the bridge's bus reset and core reset together, holds them, drops them, and waits for the bridge to settle. It then writes the eight inbound address-window registers, waits again, and writes the bridge's own PCI command register through the local-configuration port. It finishes by clearing any latched bus errors, and then it holds its done flag.

All register traffic uses one simple write master. The sequencer drives an address, a data word and a strobe. A write is taken in the cycle where the strobe and ready are both high. Each wait lasts `DELAY_CYCLES` clock cycles. The error status to be cleared comes in on two input buses, and the sequencer samples them when the command write finishes.

Top module: `pci_bridge_bringup`

## Requirements
- R1: After system reset, and until start is seen, both reset lines, the strobe, busy and done are all low.
- R2: A start pulse in the idle state raises the bus reset and the core reset together. They stay high for exactly `DELAY_CYCLES` cycles and fall together, and they rise only once per system reset.
- R3: After the reset lines fall there are exactly `DELAY_CYCLES` cycles with no strobe before the first register write.
- R4: Window N for N = 0..6 is written at address `WIN_REG_BASE + 4*N` (0x80 + 4N by default) with data 0x10000000 + N*0x01000000. Window 7 is written at 0x9C with 0x07000000. The writes go in ascending window order.
- R5: After window 7 is accepted there are exactly `DELAY_CYCLES` cycles with no strobe before the next write.
- R6: The local-configuration write first sends a command word to address 0x00: bit 16 is set to mark a write, the dword-aligned register offset 0x04 is in the low bits, and the active-low byte enables in bits 23:20 are all zero for a full dword. The resulting word is 0x00010004. It then sends 0x00000356 to address 0x04.
- R7: The two error-status buses are sampled in the cycle the command data write is accepted. The PCI error bits (2 bits) are written back to address 0x1C, and after that the AHB error bit is written back to 0x24. A write whose sampled bits are all zero is skipped, and that costs one idle cycle.
- R8: While the strobe is high and ready is low, the strobe, address and data stay unchanged. Each accepted write moves the sequence on by exactly one write.
- R9: Busy is high from start until done. Done then stays high, with busy low, until the next system reset. A start pulse while busy or done has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Start request, taken only while idle |
| pci_err_sts | input | 2 | Latched PCI-side error status bits |
| ahb_err_sts | input | 1 | Latched system-bus error status bit |
| bus_rst | output | 1 | Bridge bus reset, active high |
| core_rst | output | 1 | Bridge core reset, active high |
| wr_addr | output | AW | Register write address |
| wr_data | output | 32 | Register write data |
| wr_strobe | output | 1 | Write request |
| wr_ready | input | 1 | Target accepts the write this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, held until reset |

## Verification
The corner that is hardest to reach from the ports is the skipped error-clear write. It only shows up as one idle cycle between the command data write and the AHB clear, and it depends on the status inputs at the exact cycle the command data is accepted. The bench holds the PCI status at zero and the AHB status at one, then measures the gap before that last write. Other runs stall ready on a repeating pattern, which checks that stalled writes stay stable. One run also sends extra start pulses during the settle phase and after done, and the bench confirms that no second reset pulse and no extra write appears.

// File: rtl/pci_bridge_bringup.sv
module pci_bridge_bringup #(
  parameter int          DELAY_CYCLES   = 1000,
  parameter int          AW             = 8,
  parameter int          WIN_COUNT      = 8,
  parameter logic [AW-1:0] WIN_REG_BASE = 8'h80,
  parameter logic [31:0] WIN_FIRST      = 32'h1000_0000,
  parameter logic [31:0] WIN_STEP       = 32'h0100_0000,
  parameter logic [31:0] WIN_LAST       = 32'h0700_0000,
  parameter logic [AW-1:0] PORT_CMD     = 8'h00,
  parameter logic [AW-1:0] PORT_WDATA   = 8'h04,
  parameter logic [AW-1:0] PORT_PCI_ERR = 8'h1C,
  parameter logic [AW-1:0] PORT_AHB_ERR = 8'h24,
  parameter logic [7:0]  LOCAL_REG      = 8'h04,
  parameter logic [3:0]  LOCAL_BE_N     = 4'h0,
  parameter logic [31:0] CMD_VALUE      = 32'h0000_0356
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    pci_err_sts,
  input  logic          ahb_err_sts,
  output logic          bus_rst,
  output logic          core_rst,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          wr_strobe,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(DELAY_CYCLES + 1);
  localparam int IW = $clog2(WIN_COUNT);
  localparam logic [31:0] LOCAL_CMD_WORD =
    32'h0001_0000 | {8'h0, LOCAL_BE_N, 12'h0, LOCAL_REG & 8'hFC};

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_SETTLE, S_WIN, S_QUIET,
    S_CFG_CMD, S_CFG_DATA, S_CLR_PCI, S_CLR_AHB, S_DONE
  } state_t;

  state_t        state, state_nx;
  logic [CW-1:0] cnt;
  logic [IW-1:0] win_idx;
  logic [1:0]    snap_pci;
  logic          snap_ahb;

  wire accept    = wr_strobe & wr_ready;
  wire delay_end = (cnt == CW'(DELAY_CYCLES - 1));
  wire in_delay  = (state == S_HOLD) | (state == S_SETTLE) | (state == S_QUIET);
  wire last_win  = (win_idx == IW'(WIN_COUNT - 1));

  assign bus_rst  = (state == S_HOLD);
  assign core_rst = (state == S_HOLD);
  assign done     = (state == S_DONE);
  assign busy     = (state != S_IDLE) & (state != S_DONE);
  assign wr_strobe = (state == S_WIN) | (state == S_CFG_CMD) | (state == S_CFG_DATA)
                   | ((state == S_CLR_PCI) & (snap_pci != 2'b00))
                   | ((state == S_CLR_AHB) & snap_ahb);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:     if (start) state_nx = S_HOLD;
      S_HOLD:     if (delay_end) state_nx = S_SETTLE;
      S_SETTLE:   if (delay_end) state_nx = S_WIN;
      S_WIN:      if (accept && last_win) state_nx = S_QUIET;
      S_QUIET:    if (delay_end) state_nx = S_CFG_CMD;
      S_CFG_CMD:  if (accept) state_nx = S_CFG_DATA;
      S_CFG_DATA: if (accept) state_nx = S_CLR_PCI;
      S_CLR_PCI:  if (accept || snap_pci == 2'b00) state_nx = S_CLR_AHB;
      S_CLR_AHB:  if (accept || !snap_ahb) state_nx = S_DONE;
      default:    state_nx = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      win_idx  <= '0;
      snap_pci <= 2'b00;
      snap_ahb <= 1'b0;
    end else begin
      state <= state_nx;
      cnt   <= (in_delay && !delay_end) ? cnt + 1'b1 : '0;
      if (state == S_WIN && accept) win_idx <= win_idx + 1'b1;
      if (state == S_CFG_DATA && accept) begin
        snap_pci <= pci_err_sts;
        snap_ahb <= ahb_err_sts;
      end
    end
  end

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    case (state)
      S_WIN: begin
        wr_addr = WIN_REG_BASE + AW'({win_idx, 2'b00});
        wr_data = last_win ? WIN_LAST : WIN_FIRST + 32'(win_idx) * WIN_STEP;
      end
      S_CFG_CMD:  begin wr_addr = PORT_CMD;     wr_data = LOCAL_CMD_WORD; end
      S_CFG_DATA: begin wr_addr = PORT_WDATA;   wr_data = CMD_VALUE; end
      S_CLR_PCI:  begin wr_addr = PORT_PCI_ERR; wr_data = {30'h0, snap_pci}; end
      S_CLR_AHB:  begin wr_addr = PORT_AHB_ERR; wr_data = {31'h0, snap_ahb}; end
      default: ;
    endcase
  end

endmodule

// File: rtl/bringup_checker.sv
module bringup_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_rst,
  input logic          core_rst,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          wr_strobe,
  input logic          wr_ready,
  input logic          busy,
  input logic          done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (!wr_strobe && !bus_rst && !core_rst));

  p_reset_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst == core_rst);

  p_no_write_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> !wr_strobe);

  p_stall_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !wr_ready) |=> (wr_strobe && $stable(wr_addr) && $stable(wr_data)));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !busy));

  p_busy_runs_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_start_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !bus_rst);

endmodule

bind pci_bridge_bringup bringup_checker #(.AW(AW)) u_chk (.*);

// File: tb/sim_pci_bridge_bringup.sv
`timescale 1ns/1ps
module sim_pci_bridge_bringup;
  localparam int DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] pci_err_sts = 2'b00;
  logic ahb_err_sts = 1'b0, wr_ready = 1'b0;
  logic bus_rst, core_rst, wr_strobe, busy, done;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;

  always #10 clk = ~clk;

  pci_bridge_bringup #(.DELAY_CYCLES(DLY)) u0 (.*);

  int checks = 0, failures = 0, cyc = 0, ready_mode = 0;
  int hold_len = 0, rise_cnt = 0, gap = 0, k = 0;
  int gap_at[0:15];
  logic [39:0] exp_q[$];
  logic prev_rst = 1'b0, prev_stall = 1'b0;
  logic [7:0] prev_addr = '0;
  logic [31:0] prev_data = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    wr_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 2);
    if (rst_n) begin
      if (bus_rst !== core_rst) check(0, "R2 reset lines differ", bus_rst, core_rst);
      if (bus_rst && !prev_rst) rise_cnt++;
      if (bus_rst) begin hold_len++; gap = 0; end
      if (prev_stall) check(wr_strobe && wr_addr == prev_addr && wr_data == prev_data,
                            "R8 stalled write changed", {wr_addr, wr_data}, {prev_addr, prev_data});
      if (wr_strobe && wr_ready) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data} == e, "R4/R6/R7 write mismatch", {wr_addr, wr_data}, e);
        end
        if (k < 16) gap_at[k] = gap;
        k++;
        gap = 0;
      end else if (busy && !bus_rst && !wr_strobe) gap++;
      prev_stall = wr_strobe && !wr_ready;
      prev_addr = wr_addr;
      prev_data = wr_data;
      prev_rst = bus_rst;
    end
  end

  task automatic run_case(input logic [1:0] pe, input logic ae, input int mode, input bit poke);
    int n;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    check({bus_rst, core_rst, wr_strobe, busy, done} == 5'b0, "R1 state in reset",
          {bus_rst, core_rst, wr_strobe, busy, done}, 0);
    hold_len = 0; rise_cnt = 0; gap = 0; k = 0; prev_rst = 0; prev_stall = 0;
    exp_q.delete();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({bus_rst, wr_strobe, busy, done} == 4'b0, "R1 idle before start",
          {bus_rst, wr_strobe, busy, done}, 0);
    pci_err_sts = pe; ahb_err_sts = ae; ready_mode = mode;
    for (int i = 0; i < 8; i++)
      exp_q.push_back({8'h80 + 8'(4 * i), (i == 7) ? 32'h0700_0000 : 32'h1000_0000 + 32'(i) * 32'h0100_0000});
    exp_q.push_back({8'h00, 32'h0001_0004});
    exp_q.push_back({8'h04, 32'h0000_0356});
    if (pe != 0) exp_q.push_back({8'h1C, 30'h0, pe});
    if (ae) exp_q.push_back({8'h24, 31'h0, ae});
    n = exp_q.size();
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (DLY + 3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
    check(done && !busy, "R9 done reached, busy low", {done, busy}, 2'b10);
    check(hold_len == DLY, "R2 reset hold length", hold_len, DLY);
    check(rise_cnt == 1, "R2 single reset pulse", rise_cnt, 1);
    check(k == n, "R8 write count", k, n);
    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
    check(gap_at[0] == DLY, "R3 settle before first write", gap_at[0], DLY);
    check(gap_at[8] == DLY, "R5 quiet before command", gap_at[8], DLY);
    if (n > 10) check(gap_at[10] == ((pe == 0) ? 1 : 0), "R7 gap before error clear",
                      gap_at[10], (pe == 0) ? 1 : 0);
    pci_err_sts = 2'b11; ahb_err_sts = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (3 * DLY + 20) @(negedge clk);
    check(done && !busy && rise_cnt == 1 && k == n, "R9 start after done ignored",
          {done, busy, 8'(rise_cnt), 8'(k)}, {2'b10, 8'd1, 8'(n)});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) gap_at[i] = -1;
    run_case(2'b11, 1'b1, 0, 1'b0);
    run_case(2'b01, 1'b0, 1, 1'b0);
    run_case(2'b00, 1'b1, 1, 1'b1);
    run_case(2'b10, 1'b1, 0, 1'b1);
    run_case(2'b00, 1'b0, 1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule